// File: doc/BRIEF.md
# Shared Unit Contention Tracker

This block models the timing of instructions sent to pools of shared execution units, such as a floating-point unit that several cores share. It does not compute any arithmetic result. It decides, for each issue request, which instance of the requested pool takes the operation. It also works out how many cycles the requester must wait before that instance accepts the operation, and the absolute cycle at which the result becomes ready. All times are stamps of a free-running cycle counter inside the block.

Two pools are modelled. The base pool has several identical instances and serves the short operations. The divide pool has one instance and serves the long divides. Each operation class has its own latency and its own initiation interval, called the bandwidth. The latency says when the result can be consumed. The bandwidth says when the instance that took the operation can take the next one. A request is booked in the cycle it is presented: the chosen instance is reserved from the issue cycle on.

A consumer that needs the result before the ready cycle must stall until that cycle. This block reports the ready stamp and leaves that comparison to the consumer. The pool ID and the operation class are independent inputs. If a divide class is sent to the base pool, it occupies a base instance with the divide latency and bandwidth.

Top module: `shared_unit_tracker`

## Requirements
- R1: The internal cycle counter reads 0 in the first cycle after synchronous reset is released and grows by one on every clock. All reported cycle stamps use this counter.
- R2: Reset clears the next-accept stamp of every instance to 0. The first request to any pool after reset is therefore granted with zero stall.
- R3: Operation class codes on `reqOp` are: 0 add, 1 multiply, 2 fused multiply-add, 3 convert, 4 other, 7 spare (all of these use latency 1, bandwidth 1); 5 full-precision divide (latency 14, bandwidth 14); 6 small-float divide (latency 10, bandwidth 10).
- R4: `reqPool` 0 selects the base pool, instances 0 to 3. `reqPool` 1 selects the divide pool, instance 4. `issueInst` always names an instance of the requested pool.
- R5: Within the pool, the instance with the earliest next-accept stamp is chosen. A tie goes to the lowest instance index.
- R6: `stallCycles` is the chosen stamp minus the current cycle when the stamp lies in the future, and 0 otherwise. `grant` is 1 exactly when `reqValid` is 1 and the stall is 0.
- R7: `resultReadyCycle` equals current cycle plus stall plus the class latency.
- R8: A valid request sets the chosen instance's next-accept stamp to its issue cycle plus the class bandwidth, and these stamps never decrease outside reset. With `reqValid` low, nothing is booked and `grant`, `stallCycles`, `resultReadyCycle` and `issueInst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Issue request present this cycle |
| reqPool | input | 1 | Pool ID: 0 base, 1 divide |
| reqOp | input | 3 | Operation class code |
| grant | output | 1 | Request issues in this cycle |
| stallCycles | output | 32 | Cycles until issue |
| resultReadyCycle | output | 32 | Counter stamp at which the result is ready |
| issueInst | output | 3 | Global index of the chosen instance |

## Verification
The assertions take for granted that the run is shorter than the counter's wrap period. They also take for granted that every latency and bandwidth is at least one, so ready stamps lie strictly ahead and next-accept stamps only grow. Reset is asserted before the first request, and there is at most one request per cycle. The stimulus stays well inside these limits: it runs a few hundred cycles with the default timing values, starts from reset, and resets again mid-run only from its own task.

// File: rtl/contention_pkg.sv
package contention_pkg;
  localparam int CYC_W = 32;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_FMA   = 3'd2,
    OP_CONV  = 3'd3,
    OP_OTHER = 3'd4,
    OP_DIV   = 3'd5,
    OP_SDIV  = 3'd6,
    OP_SPARE = 3'd7
  } opClass_e;

  typedef struct packed {
    logic             book;
    logic [IDX_W-1:0] inst;
    logic [CYC_W-1:0] value;
  } bookStrobe_t;
endpackage

// File: rtl/contention_dp.sv
module contention_dp
  import contention_pkg::*;
#(
  parameter int NUM_INST = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  bookStrobe_t      strobe,
  output logic [CYC_W-1:0] cycleNow,
  output logic [CYC_W-1:0] nextAccept [NUM_INST]
);

  always_ff @(posedge clk) begin
    if (rst) cycleNow <= '0;
    else     cycleNow <= cycleNow + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_INST; i++) begin
      if (rst)
        nextAccept[i] <= '0;
      else if (strobe.book && strobe.inst == IDX_W'(i))
        nextAccept[i] <= strobe.value;
    end
  end

  // R1: free-running stamp source
  assert_counter_step_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cycleNow == $past(cycleNow) + 1'b1);

  generate
    for (genvar g = 0; g < NUM_INST; g++) begin : g_mono
      // R8: bookings only push an instance further out
      assert_accept_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> nextAccept[g] >= $past(nextAccept[g]));
    end
  endgenerate

endmodule

// File: rtl/contention_ctrl.sv
module contention_ctrl
  import contention_pkg::*;
#(
  parameter int BASE_INST = 4,
  parameter int DIV_INST  = 1,
  parameter int LAT_BASE  = 1,
  parameter int BW_BASE   = 1,
  parameter int LAT_DIV   = 14,
  parameter int BW_DIV    = 14,
  parameter int LAT_SDIV  = 10,
  parameter int BW_SDIV   = 10,
  localparam int NUM_INST = BASE_INST + DIV_INST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqPool,
  input  logic [2:0]       reqOp,
  input  logic [CYC_W-1:0] cycleNow,
  input  logic [CYC_W-1:0] nextAccept [NUM_INST],
  output bookStrobe_t      strobe,
  output logic             grant,
  output logic [CYC_W-1:0] stallCycles,
  output logic [CYC_W-1:0] resultReadyCycle,
  output logic [IDX_W-1:0] issueInst
);

  logic [CYC_W-1:0] opLat, opBw;
  logic [CYC_W-1:0] bestVal, stallAmt, issueAt;
  logic [IDX_W-1:0] bestIdx;
  logic             found;

  // per-class timing chosen by tag
  always_comb begin
    case (opClass_e'(reqOp))
      OP_DIV:  begin opLat = CYC_W'(LAT_DIV);  opBw = CYC_W'(BW_DIV);  end
      OP_SDIV: begin opLat = CYC_W'(LAT_SDIV); opBw = CYC_W'(BW_SDIV); end
      default: begin opLat = CYC_W'(LAT_BASE); opBw = CYC_W'(BW_BASE); end
    endcase
  end

  // earliest-free instance of the requested pool, lowest index on ties
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestVal = '0;
    for (int i = 0; i < NUM_INST; i++) begin
      if ((reqPool == (i >= BASE_INST)) && (!found || nextAccept[i] < bestVal)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestVal = nextAccept[i];
      end
    end
  end

  assign stallAmt = (bestVal > cycleNow) ? (bestVal - cycleNow) : '0;
  assign issueAt  = cycleNow + stallAmt;

  assign strobe.book  = reqValid && !rst;
  assign strobe.inst  = bestIdx;
  assign strobe.value = issueAt + opBw;

  assign grant            = reqValid && (stallAmt == '0);
  assign stallCycles      = reqValid ? stallAmt : '0;
  assign resultReadyCycle = reqValid ? (issueAt + opLat) : '0;
  assign issueInst        = reqValid ? bestIdx : '0;

  // R4: chosen instance lies in the requested pool
  assert_pool_member_R4: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (reqPool == (issueInst >= IDX_W'(BASE_INST))));

  // R2: all instances are free right after reset
  assert_fresh_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && $past(rst)) |-> (grant && stallCycles == '0));

  // R7: a result is never ready in the issue-request cycle
  assert_ready_ahead_R7: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> resultReadyCycle > cycleNow);

  // R8: idle cycles report nothing
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> (!grant && stallCycles == '0 && resultReadyCycle == '0));

endmodule

// File: rtl/shared_unit_tracker.sv
module shared_unit_tracker
  import contention_pkg::*;
#(
  parameter int BASE_INST = 4,
  parameter int DIV_INST  = 1,
  parameter int LAT_BASE  = 1,
  parameter int BW_BASE   = 1,
  parameter int LAT_DIV   = 14,
  parameter int BW_DIV    = 14,
  parameter int LAT_SDIV  = 10,
  parameter int BW_SDIV   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqPool,
  input  logic [2:0]       reqOp,
  output logic             grant,
  output logic [CYC_W-1:0] stallCycles,
  output logic [CYC_W-1:0] resultReadyCycle,
  output logic [IDX_W-1:0] issueInst
);

  localparam int NUM_INST = BASE_INST + DIV_INST;

  bookStrobe_t      strobe;
  logic [CYC_W-1:0] cycleNow;
  logic [CYC_W-1:0] nextAccept [NUM_INST];

  contention_ctrl #(
    .BASE_INST(BASE_INST), .DIV_INST(DIV_INST),
    .LAT_BASE(LAT_BASE), .BW_BASE(BW_BASE),
    .LAT_DIV(LAT_DIV), .BW_DIV(BW_DIV),
    .LAT_SDIV(LAT_SDIV), .BW_SDIV(BW_SDIV)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqPool(reqPool), .reqOp(reqOp),
    .cycleNow(cycleNow), .nextAccept(nextAccept),
    .strobe(strobe), .grant(grant), .stallCycles(stallCycles),
    .resultReadyCycle(resultReadyCycle), .issueInst(issueInst)
  );

  contention_dp #(.NUM_INST(NUM_INST)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cycleNow(cycleNow), .nextAccept(nextAccept)
  );

endmodule

// File: tb/tb_shared_unit_tracker.sv
module tb_shared_unit_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqPool = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic        grant;
  logic [31:0] stallCycles, resultReadyCycle;
  logic [2:0]  issueInst;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int unsigned mNow;
  int unsigned mNext [5];
  int unsigned lfsr = 32'hACE1;

  always #4 clk = ~clk;

  shared_unit_tracker dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqPool(reqPool), .reqOp(reqOp),
    .grant(grant), .stallCycles(stallCycles), .resultReadyCycle(resultReadyCycle),
    .issueInst(issueInst)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at model cycle %0d", req, what, act, exp, mNow);
    end
  endtask

  function automatic int unsigned latOf(input int op);
    if (op == 5) return 14;
    if (op == 6) return 10;
    return 1;
  endfunction

  function automatic int unsigned bwOf(input int op);
    if (op == 5) return 14;
    if (op == 6) return 10;
    return 1;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic step(input bit v, input bit p, input int op,
                      output int unsigned eStall, output int unsigned eReady, output int eInst);
    int unsigned bestV = 0;
    int best = -1;
    reqValid = v; reqPool = p; reqOp = 3'(op);
    #1;
    for (int i = 0; i < 5; i++) begin
      if ((p ? (i >= 4) : (i < 4)) && (best < 0 || mNext[i] < bestV)) begin
        best = i; bestV = mNext[i];
      end
    end
    eStall = (bestV > mNow) ? bestV - mNow : 0;
    eReady = mNow + eStall + latOf(op);
    eInst  = best;
    if (v) begin
      check("R6", "grant", grant, (eStall == 0));
      check("R6", "stallCycles", stallCycles, eStall);
      check("R7", "resultReadyCycle", resultReadyCycle, eReady);
      check("R5", "issueInst", issueInst, eInst);
      mNext[best] = mNow + eStall + bwOf(op);
    end else begin
      check("R8", "idle grant", grant, 0);
      check("R8", "idle stallCycles", stallCycles, 0);
      check("R8", "idle resultReadyCycle", resultReadyCycle, 0);
      check("R8", "idle issueInst", issueInst, 0);
    end
    @(posedge clk);
    mNow++;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mNow = 0;
    for (int i = 0; i < 5; i++) mNext[i] = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned s, r;
    int k;
    doReset();
    // idle right after reset: nothing reported (R8)
    step(0, 0, 0, s, r, k);
    // first divide at counter 1: granted, ready at 1+14 (R1, R2, R3)
    step(1, 1, 5, s, r, k);
    check("R2", "first divide stall", s, 0);
    check("R1", "first divide ready stamp", r, 15);
    check("R3", "divide latency", r - 1, 14);
    // back-to-back divide at 2 waits for stamp 15 (R6)
    step(1, 1, 5, s, r, k);
    check("R6", "second divide stall", s, 13);
    check("R4", "divide pool instance", k, 4);
    // small divide at 3 waits for 29, ready 39 (R3)
    step(1, 1, 6, s, r, k);
    check("R3", "small divide stall", s, 26);
    check("R3", "small divide ready", r, 39);
    // base pool rotation: tie to lowest, then earliest (R5)
    step(1, 0, 0, s, r, k);
    check("R5", "tie picks instance 0", k, 0);
    step(1, 0, 1, s, r, k);
    check("R5", "earliest picks instance 1", k, 1);
    // idle cycles book nothing: next divide still waits for 39 (R8)
    step(0, 1, 5, s, r, k);
    step(1, 1, 2, s, r, k);
    check("R8", "idle left divide stamp", s, 39 - 7);
    // divide class on base pool occupies a base instance (R3, R4)
    step(1, 0, 5, s, r, k);
    check("R4", "base pool instance range", (k < 4), 1);
    // mixed pseudo-random traffic, all codes including spare 7
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0] | lfsr[5], lfsr[3] & lfsr[8], int'(lfsr[14:12]), s, r, k);
    end
    // reset mid-run clears the backlog (R2)
    step(1, 1, 5, s, r, k);
    step(1, 1, 5, s, r, k);
    doReset();
    step(1, 1, 5, s, r, k);
    check("R2", "divide after reset stall", s, 0);
    check("R1", "ready stamp from counter 0", r, 14);
    for (int n = 0; n < 40; n++) step(1, n[0], (n % 8), s, r, k);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule